// File: doc/BRIEF.md
# Sixteen-Bit Combinational ALU with Status Flags

This block is a purely combinational arithmetic logic unit. Two unsigned operands, a four-bit function code and a carry input go in. A result word and four status flags come out: zero, sign, carry and overflow. The function set covers:

- add and subtract with carry, increment and decrement;
- bitwise pass, AND, OR, XOR and invert;
- logical and arithmetic shifts;
- rotates that pass through the carry input.

There is no state inside the block. The surrounding datapath registers the operands and keeps any flags it needs. Every function code defines all four flags. The two spare codes 1110 and 1111 produce a zero result with carry and overflow low, so the outputs never float.

Top module: `alu16_flags`

## Requirements
- R1: Code 0011 yields opd_a + opd_b + carry_in modulo 2^16, and flag_carry is the carry out of bit 15.
- R2: Code 0100 yields opd_a - opd_b - carry_in modulo 2^16, and flag_carry is 1 exactly when the true difference is negative (a borrow).
- R3: Code 0001 yields opd_a + 1, with flag_carry high only for opd_a = 0xFFFF. Code 0010 yields opd_a - 1, with flag_carry high only for opd_a = 0x0000.
- R4: For codes 0001, 0010, 0011 and 0100, flag_ovf is 1 exactly when the two's-complement result of the operation does not fit in 16 signed bits.
- R5: Code 0000 passes opd_a, 0101 gives AND, 0110 gives OR, 0111 gives XOR and 1000 gives NOT opd_a. For all five codes flag_carry and flag_ovf are 0.
- R6: Code 1001 shifts opd_a left with 0 into bit 0. Code 1010 shifts it right with 0 into bit 15. Code 1011 shifts it right and copies bit 15 back into bit 15. flag_carry takes the bit shifted out: opd_a[15] for the left shift and opd_a[0] for both right shifts.
- R7: Code 1100 rotates left, with carry_in entering bit 0 and opd_a[15] going to flag_carry. Code 1101 rotates right, with carry_in entering bit 15 and opd_a[0] going to flag_carry.
- R8: For codes 1001, 1010, 1100 and 1101, flag_ovf is 1 exactly when result[15] differs from opd_a[15]. For code 1011, flag_ovf is 0.
- R9: For every code, flag_sign equals result[15] and flag_zero is 1 exactly when result is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opd_a | input | 16 | First operand; the source for unary, shift and rotate codes |
| opd_b | input | 16 | Second operand |
| func_sel | input | 4 | Function code |
| carry_in | input | 1 | Carry or borrow in for add and subtract; fill bit for rotates |
| result | output | 16 | Function result |
| flag_zero | output | 1 | Result is all zeros |
| flag_sign | output | 1 | Copy of result bit 15 |
| flag_carry | output | 1 | Carry, borrow or shifted-out bit |
| flag_ovf | output | 1 | Signed overflow, or sign change on shifts and rotates |

## Verification
Directed vectors aim at the edges of the arithmetic codes:
- 0x7FFF + 1 and 0x8000 - 1 separate the signed overflow rule from the unsigned carry rule.
- 0xFFFF + 1 and 0 - 1 exercise carry and borrow together with a zero or all-ones result.
- A subtraction with equal operands and carry_in set checks that the borrow-in is honoured.

Shift and rotate vectors use 0x8001 and 0x4000 with carry_in both 0 and 1. These patterns show which bit leaves the word, which bit fills it, and whether the sign changes. Several hundred random operand and function combinations then cover ordinary values for every defined code.

// File: rtl/alu16_pkg.sv
package alu16_pkg;

    typedef enum logic [3:0] {
        OP_PASS = 4'd0,
        OP_INC  = 4'd1,
        OP_DEC  = 4'd2,
        OP_ADD  = 4'd3,
        OP_SUB  = 4'd4,
        OP_AND  = 4'd5,
        OP_OR   = 4'd6,
        OP_XOR  = 4'd7,
        OP_NOT  = 4'd8,
        OP_SHL  = 4'd9,
        OP_SHR  = 4'd10,
        OP_ASR  = 4'd11,
        OP_RLC  = 4'd12,
        OP_RRC  = 4'd13,
        OP_RSV0 = 4'd14,
        OP_RSV1 = 4'd15
    } alu_op_e;

    typedef enum logic [1:0] {
        CLS_LOGIC,
        CLS_ARITH,
        CLS_SHIFT,
        CLS_SPARE
    } op_class_e;

    typedef struct packed {
        logic carry;
        logic ovf;
    } cv_t;

    function automatic op_class_e classify(alu_op_e op);
        case (op)
            OP_INC, OP_DEC, OP_ADD, OP_SUB:         return CLS_ARITH;
            OP_SHL, OP_SHR, OP_ASR, OP_RLC, OP_RRC: return CLS_SHIFT;
            OP_RSV0, OP_RSV1:                       return CLS_SPARE;
            default:                                return CLS_LOGIC;
        endcase
    endfunction

endpackage

// File: rtl/alu16_arith.sv
module alu16_arith
    import alu16_pkg::*;
#(
    parameter int W = 16
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         cin,
    input  alu_op_e      op,
    output logic [W-1:0] sum,
    output cv_t          cv
);

    logic [W-1:0] b_sel;
    logic [W-1:0] b_eff;
    logic         c_sel;
    logic         c_eff;
    logic         do_sub;
    logic [W:0]   full;

    always_comb begin
        case (op)
            OP_INC: begin
                b_sel  = W'(1);
                c_sel  = 1'b0;
                do_sub = 1'b0;
            end
            OP_DEC: begin
                b_sel  = W'(1);
                c_sel  = 1'b0;
                do_sub = 1'b1;
            end
            OP_SUB: begin
                b_sel  = b;
                c_sel  = cin;
                do_sub = 1'b1;
            end
            default: begin
                b_sel  = b;
                c_sel  = cin;
                do_sub = 1'b0;
            end
        endcase

        // a - b - c is formed as a + ~b + ~c; the carry out is then "no borrow"
        b_eff = do_sub ? ~b_sel : b_sel;
        c_eff = do_sub ? ~c_sel : c_sel;
        full  = {1'b0, a} + {1'b0, b_eff} + {{W{1'b0}}, c_eff};
        sum   = full[W-1:0];

        cv.carry = do_sub ? ~full[W] : full[W];
        cv.ovf   = (a[W-1] == b_eff[W-1]) && (full[W-1] != a[W-1]);
    end

endmodule

// File: rtl/alu16_logic.sv
module alu16_logic
    import alu16_pkg::*;
#(
    parameter int W = 16
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  alu_op_e      op,
    output logic [W-1:0] res
);

    always_comb begin
        case (op)
            OP_AND:  res = a & b;
            OP_OR:   res = a | b;
            OP_XOR:  res = a ^ b;
            OP_NOT:  res = ~a;
            default: res = a;
        endcase
    end

endmodule

// File: rtl/alu16_shift.sv
module alu16_shift
    import alu16_pkg::*;
#(
    parameter int W = 16
) (
    input  logic [W-1:0] a,
    input  logic         cin,
    input  alu_op_e      op,
    output logic [W-1:0] res,
    output cv_t          cv
);

    localparam int MSB = W - 1;

    logic fill_lo;
    logic fill_hi;
    logic left;

    always_comb begin
        left    = (op == OP_SHL) || (op == OP_RLC);
        fill_lo = (op == OP_RLC) ? cin : 1'b0;
        case (op)
            OP_ASR:  fill_hi = a[MSB];
            OP_RRC:  fill_hi = cin;
            default: fill_hi = 1'b0;
        endcase

        if (left) begin
            res      = {a[MSB-1:0], fill_lo};
            cv.carry = a[MSB];
        end else begin
            res      = {fill_hi, a[MSB:1]};
            cv.carry = a[0];
        end

        cv.ovf = (op == OP_ASR) ? 1'b0 : (res[MSB] ^ a[MSB]);
    end

endmodule

// File: rtl/alu16_flags.sv
module alu16_flags
    import alu16_pkg::*;
#(
    parameter int W = 16
) (
    input  logic [W-1:0] opd_a,
    input  logic [W-1:0] opd_b,
    input  logic [3:0]   func_sel,
    input  logic         carry_in,
    output logic [W-1:0] result,
    output logic         flag_zero,
    output logic         flag_sign,
    output logic         flag_carry,
    output logic         flag_ovf
);

    alu_op_e      op;
    op_class_e    cls;
    logic [W-1:0] arith_res;
    logic [W-1:0] logic_res;
    logic [W-1:0] shift_res;
    cv_t          arith_cv;
    cv_t          shift_cv;
    cv_t          sel_cv;

    assign op  = alu_op_e'(func_sel);
    assign cls = classify(op);

    alu16_arith #(.W(W)) u_arith (
        .a   (opd_a),
        .b   (opd_b),
        .cin (carry_in),
        .op  (op),
        .sum (arith_res),
        .cv  (arith_cv)
    );

    alu16_logic #(.W(W)) u_logic (
        .a   (opd_a),
        .b   (opd_b),
        .op  (op),
        .res (logic_res)
    );

    alu16_shift #(.W(W)) u_shift (
        .a   (opd_a),
        .cin (carry_in),
        .op  (op),
        .res (shift_res),
        .cv  (shift_cv)
    );

    always_comb begin
        case (cls)
            CLS_ARITH: begin
                result = arith_res;
                sel_cv = arith_cv;
            end
            CLS_SHIFT: begin
                result = shift_res;
                sel_cv = shift_cv;
            end
            CLS_LOGIC: begin
                result = logic_res;
                sel_cv = '0;
            end
            default: begin
                result = '0;
                sel_cv = '0;
            end
        endcase
    end

    assign flag_carry = sel_cv.carry;
    assign flag_ovf   = sel_cv.ovf;
    assign flag_sign  = result[W-1];
    assign flag_zero  = ~|result;

endmodule

// File: rtl/alu16_flags_chk.sv
module alu16_flags_chk #(
    parameter int W = 16
) (
    input logic [W-1:0] opd_a,
    input logic [W-1:0] opd_b,
    input logic [3:0]   func_sel,
    input logic         carry_in,
    input logic [W-1:0] result,
    input logic         flag_zero,
    input logic         flag_sign,
    input logic         flag_carry,
    input logic         flag_ovf
);

    always_comb begin
        if (func_sel == 4'd0 || (func_sel >= 4'd5 && func_sel <= 4'd8))
            AST_LOGIC_NO_CV: assert (!flag_carry && !flag_ovf); // R5
        if (func_sel == 4'd0)
            AST_PASS_COPY: assert (result == opd_a); // R5
        if (func_sel == 4'd11)
            AST_ASR_NO_OVF: assert (!flag_ovf && result[W-1] == opd_a[W-1]); // R8
        if (func_sel == 4'd9)
            AST_SHL_OUTBIT: assert (flag_carry == opd_a[W-1] && !result[0]); // R6
        if (func_sel == 4'd12)
            AST_RLC_ENTRY: assert (result[0] == carry_in && flag_carry == opd_a[W-1]); // R7
        if (func_sel == 4'd13)
            AST_RRC_ENTRY: assert (result[W-1] == carry_in && flag_carry == opd_a[0]); // R7
        if (func_sel == 4'd1)
            AST_INC_WRAP: assert (flag_carry == (opd_a == {W{1'b1}})); // R3
        AST_ZERO_MATCH: assert (flag_zero == (result == '0)); // R9
        AST_SIGN_MATCH: assert (flag_sign == result[W-1]); // R9
    end

    // opd_b is unused by these checks beyond port completeness
    logic unused_b;
    assign unused_b = ^opd_b;

endmodule

bind alu16_flags alu16_flags_chk #(.W(W)) u_chk (
    .opd_a      (opd_a),
    .opd_b      (opd_b),
    .func_sel   (func_sel),
    .carry_in   (carry_in),
    .result     (result),
    .flag_zero  (flag_zero),
    .flag_sign  (flag_sign),
    .flag_carry (flag_carry),
    .flag_ovf   (flag_ovf)
);

// File: tb/sim_alu16_flags.sv
`timescale 1ns/1ps
module sim_alu16_flags;

    logic        clk = 1'b0;
    logic [15:0] opd_a = '0;
    logic [15:0] opd_b = '0;
    logic [3:0]  func_sel = '0;
    logic        carry_in = 1'b0;
    logic [15:0] result;
    logic        flag_zero, flag_sign, flag_carry, flag_ovf;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    typedef struct {
        logic [3:0]  op;
        logic [15:0] a;
        logic [15:0] b;
        logic        cin;
        logic [15:0] r;
        logic        c;
        logic        v;
    } exp_t;

    exp_t sb_q[$];

    always #4 clk = ~clk;

    alu16_flags u0 (
        .opd_a      (opd_a),
        .opd_b      (opd_b),
        .func_sel   (func_sel),
        .carry_in   (carry_in),
        .result     (result),
        .flag_zero  (flag_zero),
        .flag_sign  (flag_sign),
        .flag_carry (flag_carry),
        .flag_ovf   (flag_ovf)
    );

    function automatic string op_req(logic [3:0] op);
        case (op)
            4'd3:                  return "R1";
            4'd4:                  return "R2";
            4'd1, 4'd2:            return "R3";
            4'd9, 4'd10, 4'd11:    return "R6";
            4'd12, 4'd13:          return "R7";
            default:               return "R5";
        endcase
    endfunction

    function automatic string ovf_req(logic [3:0] op);
        if (op >= 4'd1 && op <= 4'd4) return "R4";
        if (op >= 4'd9 && op <= 4'd13) return "R8";
        return "R5";
    endfunction

    // Independent reference model built from the requirements
    function automatic exp_t model(logic [3:0] op, logic [15:0] a, logic [15:0] b, logic cin);
        exp_t e;
        int ua, ub, sa, sb, t, st;
        e.op = op; e.a = a; e.b = b; e.cin = cin;
        e.c = 1'b0; e.v = 1'b0; e.r = '0;
        ua = int'(a); ub = int'(b);
        sa = int'($signed(a)); sb = int'($signed(b));
        case (op)
            4'd0: e.r = a;
            4'd1, 4'd2, 4'd3, 4'd4: begin
                if (op == 4'd1) begin t = ua + 1;              st = sa + 1;              end
                else if (op == 4'd2) begin t = ua - 1;         st = sa - 1;              end
                else if (op == 4'd3) begin t = ua + ub + cin;  st = sa + sb + cin;       end
                else begin t = ua - ub - cin;                  st = sa - sb - cin;       end
                e.r = t[15:0];
                e.c = (t > 65535) || (t < 0);
                e.v = (st > 32767) || (st < -32768);
            end
            4'd5: e.r = a & b;
            4'd6: e.r = a | b;
            4'd7: e.r = a ^ b;
            4'd8: e.r = ~a;
            4'd9:  begin e.r = a << 1;                e.c = a[15]; end
            4'd10: begin e.r = a >> 1;                e.c = a[0];  end
            4'd11: begin e.r = {a[15], a[15:1]};      e.c = a[0];  end
            4'd12: begin e.r = {a[14:0], cin};        e.c = a[15]; end
            4'd13: begin e.r = {cin, a[15:1]};        e.c = a[0];  end
            default: e.r = '0;
        endcase
        if (op >= 4'd9 && op <= 4'd13 && op != 4'd11) e.v = e.r[15] ^ a[15];
        return e;
    endfunction

    task automatic drive(logic [3:0] op, logic [15:0] a, logic [15:0] b, logic cin);
        @(negedge clk);
        func_sel = op; opd_a = a; opd_b = b; carry_in = cin;
        sb_q.push_back(model(op, a, b, cin));
    endtask

    always @(posedge clk) begin
        if (sb_q.size() > 0) begin
            exp_t e;
            e = sb_q.pop_front();
            total++;
            if (result !== e.r || flag_carry !== e.c) begin
                bad++;
                $display("FAIL %s op=%0d a=%h b=%h cin=%0d: result/carry got %h/%0d exp %h/%0d",
                         op_req(e.op), e.op, e.a, e.b, e.cin, result, flag_carry, e.r, e.c);
            end
            total++;
            if (flag_ovf !== e.v) begin
                bad++;
                $display("FAIL %s op=%0d a=%h b=%h cin=%0d: ovf got %0d exp %0d",
                         ovf_req(e.op), e.op, e.a, e.b, e.cin, flag_ovf, e.v);
            end
            total++;
            if (flag_sign !== e.r[15] || flag_zero !== (e.r == 16'h0)) begin // R9
                bad++;
                $display("FAIL R9 op=%0d: sign/zero got %0d/%0d exp %0d/%0d",
                         e.op, flag_sign, flag_zero, e.r[15], (e.r == 16'h0));
            end
        end
    end

    initial begin
        // idle inputs: pass of zero, zero flag set (R5, R9)
        drive(4'd0, 16'h0000, 16'h0000, 1'b0);
        // R1 add
        drive(4'd3, 16'h1234, 16'h1111, 1'b1);
        drive(4'd3, 16'hFFFF, 16'h0001, 1'b0);
        drive(4'd3, 16'h7FFF, 16'h0000, 1'b1);
        drive(4'd3, 16'h8000, 16'h8000, 1'b0);
        // R2 subtract
        drive(4'd4, 16'h0000, 16'h0001, 1'b0);
        drive(4'd4, 16'h8000, 16'h0001, 1'b0);
        drive(4'd4, 16'h5555, 16'h5555, 1'b1);
        drive(4'd4, 16'h7FFF, 16'hFFFF, 1'b0);
        // R3 increment and decrement
        drive(4'd1, 16'hFFFF, 16'h0000, 1'b1);
        drive(4'd1, 16'h7FFF, 16'h0000, 1'b0);
        drive(4'd2, 16'h0000, 16'h0000, 1'b1);
        drive(4'd2, 16'h8000, 16'h0000, 1'b0);
        // R5 logic
        drive(4'd0, 16'hA5A5, 16'hFFFF, 1'b1);
        drive(4'd5, 16'hF0F0, 16'h3C3C, 1'b1);
        drive(4'd6, 16'hF0F0, 16'h0F0F, 1'b0);
        drive(4'd7, 16'hFFFF, 16'hFFFF, 1'b1);
        drive(4'd8, 16'hFFFF, 16'h0000, 1'b0);
        // R6 / R8 shifts
        drive(4'd9,  16'h8001, 16'h0, 1'b1);
        drive(4'd9,  16'h4000, 16'h0, 1'b0);
        drive(4'd10, 16'h8001, 16'h0, 1'b1);
        drive(4'd11, 16'h8001, 16'h0, 1'b0);
        drive(4'd11, 16'h0001, 16'h0, 1'b1);
        // R7 / R8 rotates
        drive(4'd12, 16'h8000, 16'h0, 1'b0);
        drive(4'd12, 16'h4000, 16'h0, 1'b1);
        drive(4'd13, 16'h0001, 16'h0, 1'b0);
        drive(4'd13, 16'h0001, 16'h0, 1'b1);
        // random coverage of codes 0..13
        for (int i = 0; i < 400; i++) begin
            drive(4'($urandom_range(0, 13)), 16'($urandom), 16'($urandom), 1'($urandom));
        end
        repeat (3) @(negedge clk);
        if (!done) begin
            done = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            done = 1;
            total++;
            bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule